// File: doc/BRIEF.md
# Single-precision float arithmetic unit

This block performs one of four operations on a pair of 32-bit single-precision operands: addition, subtraction, multiplication or magnitude comparison. The operation is chosen by a 2-bit selector. Each operand is split into a sign, an 8-bit biased exponent (bias 127) and a 24-bit mantissa formed by putting an implicit one in front of the 23 stored fraction bits. The selected datapath combines the fields, brings the mantissa back to the form 1.f, and repacks a 32-bit word.

The arithmetic is deliberately simple and truncating. There is no rounding and no treatment of denormals, infinities or NaN: every operand is read with a hidden one, whatever its exponent. Exponent overflow and underflow wrap within 8 bits. A caller keeps operands inside the normal range. The block accepts one operation per cycle with an input strobe. The result word and an output strobe are registered and appear one clock later. The result register holds its value across cycles with no request.

Top module: `fpu_core`

## Requirements
- R1: Operand bits are sign [31], exponent [30:23] and fraction [22:0], and the mantissa is {1, fraction}. The selector `op_sel` encodes 00 = add, 01 = subtract (A − B), 10 = multiply and 11 = compare.
- R2: A request with `in_valid` high is captured at a rising edge. `res_valid` is high in the cycle after that edge, `res_word` holds the result in that same cycle, and `res_valid` is low after any edge that saw `in_valid` low.
- R3: While `in_valid` is low, `res_word` keeps its previous value, whatever `op_sel`, `opnd_a` and `opnd_b` do.
- R4: Synchronous active-high reset clears `res_word` to zero and `res_valid` to 0.
- R5: In add and subtract, the result starts from the larger exponent. The other mantissa is shifted right by the exponent difference and its low bits are dropped, so a difference of 24 or more contributes nothing.
- R6: In add, equal signs sum the aligned mantissas and keep the common sign. Unequal signs subtract the smaller aligned mantissa from the larger, and the result takes the sign of the operand with the larger aligned mantissa. B's sign is taken when the two are equal.
- R7: Subtract behaves as add with B's sign inverted, so equal signs subtract the magnitudes and opposite signs add them.
- R8: A carry out of the 24-bit mantissa sum shifts it right by one place, dropping the low bit, and raises the exponent by one.
- R9: A sum with no carry and a leading zero is shifted left until bit 23 is 1, and the exponent is lowered by the shift amount.
- R10: An add or subtract whose mantissa result is zero yields the all-zero word 0x00000000.
- R11: Multiply gives sign = sA XOR sB and exponent = eA + eB − 127. The 48-bit mantissa product is taken from bit 47 (exponent + 1) when that bit is set, and from bit 46 otherwise, and the fraction is truncated to 23 bits.
- R12: Compare returns code 01 when A > B, 10 when A < B and 00 when A = B, in bits [1:0], with bits [31:2] zero.
- R13: Compare decides by sign first (the operand with sign 1 is smaller), then by exponent, then by fraction. When both signs are equal, the larger exponent/fraction is reported as greater even when both operands are negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 2 | Operation select: 00 add, 01 subtract, 10 multiply, 11 compare |
| opnd_a | input | 32 | Operand A, single-precision layout |
| opnd_b | input | 32 | Operand B, single-precision layout |
| in_valid | input | 1 | Request strobe; captures the inputs at the next rising edge |
| res_word | output | 32 | Registered result word |
| res_valid | output | 1 | High for one cycle per accepted request |

## Verification
State in this block is small: the result register and the output strobe. Any fault in the datapath therefore shows in `res_word` one cycle after the offending request. A bad alignment shift or sign pick shows up as a wrong exponent or sign in the same word. A normaliser fault shows as a mantissa whose top bit is clear or an exponent off by the shift count. A fault in the capture enable shows up as a result that changes during idle cycles, or a strobe that stays high, visible on the first idle edge. Directed operands target each branch: carry, cancellation, wide exponent gaps, both product ranges and every compare outcome. Random normal-range operands are checked against a separately written truncating model.

// File: rtl/fpu_pkg.sv
package fpu_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int MANT_W = FRAC_W + 1;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int PROD_W = 2 * MANT_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int LZ_W   = $clog2(MANT_W + 1);

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_CMP = 2'b11
    } fpu_op_e;

    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_GT = 2'b01,
        CMP_LT = 2'b10
    } cmp_code_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
    } fp_fields_t;

    // Split a word into fields, prepending the implicit leading one.
    function automatic fp_fields_t fp_unpack(input logic [WORD_W-1:0] w);
        fp_fields_t f;
        f.sign = w[WORD_W-1];
        f.exp  = w[WORD_W-2 -: EXP_W];
        f.mant = {1'b1, w[FRAC_W-1:0]};
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] fp_pack(input logic s,
                                                  input logic [EXP_W-1:0] e,
                                                  input logic [FRAC_W-1:0] f);
        return {s, e, f};
    endfunction

    // Number of zero bits above the first one; MANT_W for an all-zero input.
    function automatic logic [LZ_W-1:0] lead_zeros(input logic [MANT_W-1:0] m);
        logic [LZ_W-1:0] n;
        logic            seen;
        n    = '0;
        seen = 1'b0;
        for (int i = MANT_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (m[i]) seen = 1'b1;
                else      n    = n + 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fpu_norm.sv
module fpu_norm
    import fpu_pkg::*;
(
    input  logic              sign_in,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [MANT_W:0]   sum_in,
    output logic [WORD_W-1:0] word_out
);

    logic [LZ_W-1:0]   lz;
    logic [MANT_W-1:0] shifted;
    logic [EXP_W-1:0]  exp_n;
    logic [FRAC_W-1:0] frac_n;

    always_comb begin
        lz      = lead_zeros(sum_in[MANT_W-1:0]);
        shifted = sum_in[MANT_W-1:0] << lz;
        if (sum_in[MANT_W]) begin
            // carry out: drop the lowest bit, bump the exponent
            frac_n = sum_in[MANT_W-1:1];
            exp_n  = exp_in + 1'b1;
        end else begin
            frac_n = shifted[FRAC_W-1:0];
            exp_n  = exp_in - EXP_W'(lz);
        end
        if (sum_in == '0) word_out = '0;
        else              word_out = fp_pack(sign_in, exp_n, frac_n);
    end

endmodule

// File: rtl/fpu_addsub.sv
module fpu_addsub
    import fpu_pkg::*;
(
    input  logic              do_sub,
    input  fp_fields_t        fa,
    input  fp_fields_t        fb,
    output logic [WORD_W-1:0] word_out
);

    logic              sb_eff;
    logic              a_big;
    logic [EXP_W-1:0]  diff;
    logic [EXP_W-1:0]  exp_base;
    logic [MANT_W-1:0] ma_al;
    logic [MANT_W-1:0] mb_al;
    logic [MANT_W:0]   sum;
    logic              sign_r;

    always_comb begin
        sb_eff   = fb.sign ^ do_sub;
        a_big    = (fa.exp >= fb.exp);
        diff     = a_big ? (fa.exp - fb.exp) : (fb.exp - fa.exp);
        exp_base = a_big ? fa.exp : fb.exp;
        ma_al    = a_big ? fa.mant : (fa.mant >> diff);
        mb_al    = a_big ? (fb.mant >> diff) : fb.mant;

        if (fa.sign == sb_eff) begin
            sum    = {1'b0, ma_al} + {1'b0, mb_al};
            sign_r = fa.sign;
        end else if (ma_al > mb_al) begin
            sum    = {1'b0, ma_al} - {1'b0, mb_al};
            sign_r = fa.sign;
        end else begin
            sum    = {1'b0, mb_al} - {1'b0, ma_al};
            sign_r = sb_eff;
        end
    end

    fpu_norm u_norm (
        .sign_in  (sign_r),
        .exp_in   (exp_base),
        .sum_in   (sum),
        .word_out (word_out)
    );

endmodule

// File: rtl/fpu_mul.sv
module fpu_mul
    import fpu_pkg::*;
(
    input  fp_fields_t        fa,
    input  fp_fields_t        fb,
    output logic [WORD_W-1:0] word_out
);

    logic [PROD_W-1:0]  prod;
    logic [EXP_W+1:0]   exp_wide;
    logic [EXP_W-1:0]   exp_n;
    logic [FRAC_W-1:0]  frac_n;

    always_comb begin
        prod     = PROD_W'(fa.mant) * PROD_W'(fb.mant);
        exp_wide = {2'b00, fa.exp} + {2'b00, fb.exp} - (EXP_W+2)'(BIAS);
        if (prod[PROD_W-1]) begin
            frac_n = prod[PROD_W-2 -: FRAC_W];
            exp_n  = exp_wide[EXP_W-1:0] + 1'b1;
        end else begin
            frac_n = prod[PROD_W-3 -: FRAC_W];
            exp_n  = exp_wide[EXP_W-1:0];
        end
        word_out = fp_pack(fa.sign ^ fb.sign, exp_n, frac_n);
    end

endmodule

// File: rtl/fpu_cmp.sv
module fpu_cmp
    import fpu_pkg::*;
(
    input  fp_fields_t        fa,
    input  fp_fields_t        fb,
    output logic [WORD_W-1:0] word_out
);

    cmp_code_e code;

    always_comb begin
        if (fa.sign && !fb.sign)       code = CMP_LT;
        else if (fb.sign && !fa.sign)  code = CMP_GT;
        else if (fa.exp > fb.exp)      code = CMP_GT;
        else if (fb.exp > fa.exp)      code = CMP_LT;
        else if (fa.mant > fb.mant)    code = CMP_GT;
        else if (fb.mant > fa.mant)    code = CMP_LT;
        else                           code = CMP_EQ;
        word_out = {{(WORD_W-2){1'b0}}, code};
    end

endmodule

// File: rtl/fpu_core.sv
module fpu_core
    import fpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_sel,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic              in_valid,
    output logic [WORD_W-1:0] res_word,
    output logic              res_valid
);

    fp_fields_t        fa;
    fp_fields_t        fb;
    fpu_op_e           op;
    logic [WORD_W-1:0] as_word;
    logic [WORD_W-1:0] mul_word;
    logic [WORD_W-1:0] cmp_word;
    logic [WORD_W-1:0] next_word;

    assign fa = fp_unpack(opnd_a);
    assign fb = fp_unpack(opnd_b);
    assign op = fpu_op_e'(op_sel);

    fpu_addsub u_addsub (
        .do_sub   (op == OP_SUB),
        .fa       (fa),
        .fb       (fb),
        .word_out (as_word)
    );

    fpu_mul u_mul (
        .fa       (fa),
        .fb       (fb),
        .word_out (mul_word)
    );

    fpu_cmp u_cmp (
        .fa       (fa),
        .fb       (fb),
        .word_out (cmp_word)
    );

    always_comb begin
        unique case (op)
            OP_MUL:  next_word = mul_word;
            OP_CMP:  next_word = cmp_word;
            default: next_word = as_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_word  <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) res_word <= next_word;
        end
    end

endmodule

// File: rtl/fpu_core_chk.sv
module fpu_core_chk
    import fpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        op_sel,
    input logic [WORD_W-1:0] opnd_a,
    input logic [WORD_W-1:0] opnd_b,
    input logic              in_valid,
    input logic [WORD_W-1:0] res_word,
    input logic              res_valid
);

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    // R2
    strobe_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_word));

    // R12
    cmp_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b11) |=> (res_word[WORD_W-1:2] == '0 && res_word[1:0] != 2'b11));

    // R13
    cmp_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b11 && opnd_a[WORD_W-1] && !opnd_b[WORD_W-1]) |=> (res_word == 32'd2));

    // R11
    mul_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b10) |=> (res_word[WORD_W-1] == ($past(opnd_a[WORD_W-1]) ^ $past(opnd_b[WORD_W-1]))));

    // R10
    self_sub_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b01 && opnd_a == opnd_b) |=> (res_word == '0));

endmodule

bind fpu_core fpu_core_chk u_chk (.*);

// File: tb/tb_fpu_core.sv
`timescale 1ns/1ps
module tb_fpu_core;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  op_sel;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        in_valid;
    logic [31:0] res_word;
    logic        res_valid;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    fpu_core dut (
        .clk       (clk),
        .rst       (rst),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .in_valid  (in_valid),
        .res_word  (res_word),
        .res_valid (res_valid)
    );

    // ---------------- truncating reference model ----------------
    function automatic logic [31:0] ref_addsub(input logic [31:0] x, input logic [31:0] y, input bit sub);
        longint mx, my, m;
        int     ex, ey, e, d;
        bit     sx, sy, s;
        sx = x[31]; sy = y[31] ^ sub;
        ex = int'(x[30:23]); ey = int'(y[30:23]);
        mx = longint'({1'b1, x[22:0]}); my = longint'({1'b1, y[22:0]});
        if (ex >= ey) begin
            e = ex; d = ex - ey;
            my = (d >= 24) ? 0 : (my >> d);
        end else begin
            e = ey; d = ey - ex;
            mx = (d >= 24) ? 0 : (mx >> d);
        end
        if (sx == sy)     begin m = mx + my; s = sx; end
        else if (mx > my) begin m = mx - my; s = sx; end
        else              begin m = my - mx; s = sy; end
        if (m == 0) return 32'h0;
        while (m >= 64'd16777216) begin m = m >> 1; e = e + 1; end
        while (m <  64'd8388608)  begin m = m << 1; e = e - 1; end
        return {s, 8'(e), 23'(m)};
    endfunction

    function automatic logic [31:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
        longint m;
        int     e;
        m = longint'({1'b1, x[22:0]}) * longint'({1'b1, y[22:0]});
        e = int'(x[30:23]) + int'(y[30:23]) - 127;
        m = m >> 23;
        while (m >= 64'd16777216) begin m = m >> 1; e = e + 1; end
        return {x[31] ^ y[31], 8'(e), 23'(m)};
    endfunction

    function automatic logic [31:0] ref_cmp(input logic [31:0] x, input logic [31:0] y);
        if (x == y)            return 32'd0;
        if (x[31] != y[31])    return x[31] ? 32'd2 : 32'd1;
        return (x[30:0] > y[30:0]) ? 32'd1 : 32'd2;
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [31:0] x, input logic [31:0] y,
                         output logic [31:0] r, output logic v);
        @(negedge clk);
        op_sel = op; opnd_a = x; opnd_b = y; in_valid = 1'b1;
        @(negedge clk);
        r = res_word; v = res_valid;
        in_valid = 1'b0;
    endtask

    task automatic run_op(input string tag, input logic [1:0] op, input logic [31:0] x,
                          input logic [31:0] y, input logic [31:0] exp);
        logic [31:0] r;
        logic        v;
        issue(op, x, y, r, v);
        check(tag, r, exp);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        @(negedge clk);
        check("R4 reset result", res_word, 32'h0);
        check("R4 reset strobe", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_latency;
        logic [31:0] r;
        logic        v;
        issue(2'b00, 32'h3F800000, 32'h3F800000, r, v);
        check("R2 strobe one cycle later", {31'd0, v}, 32'd1);
        check("R2 result in strobe cycle", r, 32'h40000000);
        @(negedge clk);
        check("R2 strobe drops", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_hold;
        logic [31:0] r;
        logic        v;
        issue(2'b10, 32'h40000000, 32'h40400000, r, v);
        @(negedge clk);
        op_sel = 2'b00; opnd_a = 32'h3F800000; opnd_b = 32'h3F800000;
        repeat (3) @(negedge clk);
        check("R3 idle keeps result", res_word, 32'h40C00000);
        check("R3 idle strobe low", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_add;
        run_op("R1 R6 add 1.5+2.25", 2'b00, 32'h3FC00000, 32'h40100000, 32'h40700000);
        run_op("R6 add mixed sign 1+(-3)", 2'b00, 32'h3F800000, 32'hC0400000, 32'hC0000000);
        run_op("R6 add mixed sign -1+3", 2'b00, 32'hBF800000, 32'h40400000, 32'h40000000);
        run_op("R8 carry 1.5+1.5", 2'b00, 32'h3FC00000, 32'h3FC00000, 32'h40400000);
    endtask

    task automatic t_align;
        run_op("R5 gap 30 ignored", 2'b00, 32'h3F800000, 32'h30800000, 32'h3F800000);
        run_op("R5 gap 30 swapped", 2'b00, 32'h30800000, 32'h3F800000, 32'h3F800000);
        run_op("R5 gap 1 align 2+1", 2'b00, 32'h40000000, 32'h3F800000, 32'h40400000);
    endtask

    task automatic t_sub;
        run_op("R7 sub 3-1", 2'b01, 32'h40400000, 32'h3F800000, 32'h40000000);
        run_op("R7 sub 1-(-1)", 2'b01, 32'h3F800000, 32'hBF800000, 32'h40000000);
        run_op("R7 sub 1-3", 2'b01, 32'h3F800000, 32'h40400000, 32'hC0000000);
    endtask

    task automatic t_norm;
        run_op("R9 left norm 1-0.75", 2'b01, 32'h3F800000, 32'h3F400000, 32'h3E800000);
        run_op("R10 zero 2-2", 2'b01, 32'h40000000, 32'h40000000, 32'h00000000);
        run_op("R10 zero 5+(-5)", 2'b00, 32'h40A00000, 32'hC0A00000, 32'h00000000);
    endtask

    task automatic t_mul;
        run_op("R11 mul 2*3 bit46", 2'b10, 32'h40000000, 32'h40400000, 32'h40C00000);
        run_op("R11 mul 1.5*1.5 bit47", 2'b10, 32'h3FC00000, 32'h3FC00000, 32'h40100000);
        run_op("R11 mul -2*3", 2'b10, 32'hC0000000, 32'h40400000, 32'hC0C00000);
    endtask

    task automatic t_cmp;
        run_op("R12 cmp 2>1", 2'b11, 32'h40000000, 32'h3F800000, 32'h00000001);
        run_op("R12 cmp 1<2", 2'b11, 32'h3F800000, 32'h40000000, 32'h00000002);
        run_op("R12 cmp equal", 2'b11, 32'h40400000, 32'h40400000, 32'h00000000);
        run_op("R13 cmp sign -1<1", 2'b11, 32'hBF800000, 32'h3F800000, 32'h00000002);
        run_op("R13 cmp fraction 1.5>1", 2'b11, 32'h3FC00000, 32'h3F800000, 32'h00000001);
        run_op("R13 cmp both negative", 2'b11, 32'hC0000000, 32'hBF800000, 32'h00000001);
    endtask

    function automatic logic [31:0] rnd_word;
        logic [7:0] e;
        e = 8'($urandom_range(154, 100));
        return {1'($urandom_range(1, 0)), e, 23'($urandom)};
    endfunction

    task automatic t_random;
        for (int i = 0; i < 80; i++) begin
            logic [31:0] x, y;
            x = rnd_word();
            y = rnd_word();
            if (i % 5 == 0) y = {~x[31], x[30:23], y[22:0]};
            run_op("R5 R6 R8 R9 random add", 2'b00, x, y, ref_addsub(x, y, 1'b0));
            run_op("R7 random sub", 2'b01, x, y, ref_addsub(x, y, 1'b1));
            run_op("R11 random mul", 2'b10, x, y, ref_mul(x, y));
            run_op("R12 R13 random cmp", 2'b11, x, y, ref_cmp(x, y));
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sel = 2'b00; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_latency();
        t_hold();
        t_add();
        t_align();
        t_sub();
        t_norm();
        t_mul();
        t_cmp();
        t_random();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule